// File: doc/BRIEF.md
# Streaming Frame Variance Engine

This block takes a stream of signed samples, one per cycle in which the input valid is high, and cuts it into consecutive frames of a fixed number of samples. The frames do not overlap. For every frame it reports the population variance and the mean. It works in a single pass. Each accepted sample adds to a running sum and to a running sum of squares, so no frame is ever stored. When the last sample of a frame arrives, both totals are handed to a short result pipeline. That pipeline divides each total by the frame length, squares the mean, and subtracts the squared mean from the mean square.

The quotients are kept with extra fraction bits, and the mean is squared at full width, so the subtraction does not lose precision. The accumulators are sized from the frame length and cannot overflow. The frame length is fixed when the block is built. If it is a power of two, the divide is a shift. Otherwise it is a multiply by a wide precomputed reciprocal. Both forms give the exact floor quotient. The accumulators restart on the cycle after a frame ends, so the next frame can begin with no gap.

Top module: `frame_variance`

## Requirements
- R1: A synchronous active-low reset clears the sample count, both accumulators, out_valid, out_mean and out_var to zero. Samples presented while reset is low are not counted, and a partial frame in progress at reset is discarded.
- R2: A sample is accepted only in a cycle with in_valid high. Cycles with in_valid low leave the frame contents and the count unchanged. Each group of FRAME_LEN accepted samples forms one frame, and frames do not overlap.
- R3: out_mean is floor(S·2^FRAC_W / FRAME_LEN), where S is the frame's sample sum. It is a two's-complement number of DATA_W+FRAC_W bits with FRAC_W fraction bits.
- R4: out_var equals floor(Q·2^(2·FRAC_W) / FRAME_LEN) minus out_mean squared, where Q is the frame's sum of squares. It is an unsigned number of 2·DATA_W+2·FRAC_W bits with 2·FRAC_W fraction bits.
- R5: When the subtraction in R4 is negative because of the floor operations, out_var is zero.
- R6: Frames made entirely of full-scale samples (-2^(DATA_W-1) or 2^(DATA_W-1)-1, in any mix) give results that follow R3 and R4 exactly, with no wrap in any accumulator.
- R7: out_valid is high for exactly one cycle. That cycle is the fourth cycle after the cycle in which the last sample of a frame is accepted. out_valid never rises without such a frame end.
- R8: Frames may follow each other with no idle cycle. The sample accepted in the cycle after a frame's last sample is the first sample of the next frame, and every frame produces its own result.
- R9: The R3 and R4 results are exact for both a power-of-two FRAME_LEN (shift divide) and a non-power-of-two FRAME_LEN (reciprocal multiply).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data for this cycle |
| in_data | input | DATA_W (16) | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new frame result |
| out_mean | output | DATA_W+FRAC_W (20) | Signed frame mean with FRAC_W fraction bits |
| out_var | output | 2·DATA_W+2·FRAC_W (40) | Unsigned frame variance with 2·FRAC_W fraction bits |

## Verification
The hardest case to reach from the ports is the clamp in R5. It only happens when the floored mean is pulled far enough away from zero that its square exceeds the floored mean square. This needs a negative mean and a very small spread, which a ramp or a random stream almost never produces. The bench builds this case on purpose. It forces frame alignment with a reset and then repeats a five-sample pattern of four -1 values and one 0. It also sweeps every pair of small values from -12 to 12. Two instances run side by side, one with a power-of-two frame and one without, so both divide forms see every frame. The reference is exact integer arithmetic with floor division.

// File: rtl/fvar_pkg.sv
// Package: fvar_pkg
// Shared helpers for the frame variance engine.
// Assumes only that callers pass positive integer constants.
package fvar_pkg;

    // True when v is a non-zero power of two.
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/fvar_accum.sv
// Module: fvar_accum
// Counts accepted samples within a frame. It keeps the running sum and the
// running sum of squares, and it snapshots both totals, including the last
// sample, when a frame ends.
// Assumes FRAME_LEN >= 2, CNT_W = clog2(FRAME_LEN), SUM_W = DATA_W + CNT_W
// and SQ_W = 2*DATA_W + CNT_W. These widths are enough that neither total
// can wrap.
module fvar_accum #(
    parameter int DATA_W    = 16,
    parameter int FRAME_LEN = 1000,
    parameter int CNT_W     = 10,
    parameter int SUM_W     = 26,
    parameter int SQ_W      = 42
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     frame_done,
    output logic [CNT_W-1:0]         cnt,
    output logic signed [SUM_W-1:0]  acc_sum,
    output logic [SQ_W-1:0]          acc_sq,
    output logic                     snap_valid,
    output logic signed [SUM_W-1:0]  snap_sum,
    output logic [SQ_W-1:0]          snap_sq
);

    logic signed [2*DATA_W-1:0] sample_sq;
    logic signed [SUM_W-1:0]    sum_next;
    logic [SQ_W-1:0]            sq_next;

    // Square of the incoming sample, always non-negative.
    assign sample_sq  = in_data * in_data;
    // Totals that include the sample presented this cycle.
    assign sum_next   = acc_sum + SUM_W'(in_data);
    assign sq_next    = acc_sq + SQ_W'($unsigned(sample_sq));
    // The last sample of a frame is being accepted.
    assign frame_done = in_valid && (cnt == CNT_W'(FRAME_LEN - 1));

    // Advance the count and the totals; restart both after the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            acc_sum <= '0;
            acc_sq  <= '0;
        end else if (in_valid) begin
            if (frame_done) begin
                cnt     <= '0;
                acc_sum <= '0;
                acc_sq  <= '0;
            end else begin
                cnt     <= cnt + CNT_W'(1);
                acc_sum <= sum_next;
                acc_sq  <= sq_next;
            end
        end
    end

    // Capture the completed frame totals for the result pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_valid <= 1'b0;
            snap_sum   <= '0;
            snap_sq    <= '0;
        end else begin
            snap_valid <= frame_done;
            if (frame_done) begin
                snap_sum <= sum_next;
                snap_sq  <= sq_next;
            end
        end
    end

endmodule

// File: rtl/fvar_divn.sv
// Module: fvar_divn
// Registered unsigned divide by the frame length that keeps SHIFT_UP extra
// fraction bits: q = floor(v * 2^SHIFT_UP / FRAME_LEN).
// For a power-of-two FRAME_LEN this is only a shift. Otherwise v is multiplied
// by K = floor(2^RS / FRAME_LEN) + 1, with RS large enough that the error stays
// below 1/FRAME_LEN, so the floor is exact.
// Assumes LOG2N = clog2(FRAME_LEN) and that OUT_W is wide enough for the quotient.
module fvar_divn #(
    parameter int FRAME_LEN = 1000,
    parameter int LOG2N     = 10,
    parameter int IN_W      = 26,
    parameter int SHIFT_UP  = 4,
    parameter int OUT_W     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  v,
    output logic [OUT_W-1:0] q
);

    localparam bit IS_POW2 = fvar_pkg::is_pow2(FRAME_LEN);

    logic [OUT_W-1:0] q_c;

    generate
        if (IS_POW2) begin : g_shift
            localparam int WIDE_W = IN_W + SHIFT_UP;
            // The binary point moves: scale up, then shift down by log2(N).
            assign q_c = OUT_W'((WIDE_W'(v) << SHIFT_UP) >> LOG2N);
        end else begin : g_recip
            localparam int RS = IN_W + SHIFT_UP + LOG2N;
            localparam int PW = IN_W + RS + 1;
            localparam logic [RS:0] TWO_RS = {1'b1, {RS{1'b0}}};
            localparam logic [RS:0] RECIP  = TWO_RS / (RS + 1)'(FRAME_LEN) + (RS + 1)'(1);
            // Multiply by the rounded-up reciprocal, then drop the spare bits.
            assign q_c = OUT_W'(({{(RS + 1){1'b0}}, v} * {{IN_W{1'b0}}, RECIP})
                                >> (RS - SHIFT_UP));
            if (PW < IN_W) begin : g_never
                // PW is never below IN_W; this branch is intentionally empty.
            end
        end
    endgenerate

    // Register the quotient as one pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_c;
    end

endmodule

// File: rtl/fvar_finish.sv
// Module: fvar_finish
// Last two stages of the result path. It removes the bias from the mean
// quotient and squares the mean at full width, then subtracts the squared mean
// from the mean square and clamps a negative difference to zero.
// Assumes q_mean holds floor((S + N*2^(DATA_W-1)) * 2^FRAC_W / N), so
// removing the bias only inverts its top bit.
module fvar_finish #(
    parameter int MEAN_W = 20,
    parameter int MSQ_W  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [MEAN_W-1:0]        q_mean,
    input  logic [MSQ_W-1:0]         q_msq,
    output logic                     out_valid,
    output logic signed [MEAN_W-1:0] out_mean,
    output logic [MSQ_W-1:0]         out_var
);

    localparam int SQ_W   = 2 * MEAN_W;
    localparam int DIFF_W = (MSQ_W > SQ_W ? MSQ_W : SQ_W) + 2;

    logic signed [MEAN_W-1:0] mean_c;
    logic signed [SQ_W-1:0]   mean_sq_c;
    logic                     s3_valid;
    logic signed [MEAN_W-1:0] s3_mean;
    logic [SQ_W-1:0]          s3_sq;
    logic [MSQ_W-1:0]         s3_msq;
    logic signed [DIFF_W-1:0] diff;

    // Remove the offset 2^(MEAN_W-1) that kept the divider unsigned.
    assign mean_c    = $signed({~q_mean[MEAN_W-1], q_mean[MEAN_W-2:0]});
    // Full-width square of the fixed-point mean.
    assign mean_sq_c = mean_c * mean_c;
    // Variance before the clamp.
    assign diff      = $signed(DIFF_W'(s3_msq)) - $signed(DIFF_W'(s3_sq));

    // Stage 3: hold the mean, its square and the mean square.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_valid <= 1'b0;
            s3_mean  <= '0;
            s3_sq    <= '0;
            s3_msq   <= '0;
        end else begin
            s3_valid <= in_valid;
            if (in_valid) begin
                s3_mean <= mean_c;
                s3_sq   <= $unsigned(mean_sq_c);
                s3_msq  <= q_msq;
            end
        end
    end

    // Stage 4: subtract, clamp at zero and publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mean  <= '0;
            out_var   <= '0;
        end else begin
            out_valid <= s3_valid;
            if (s3_valid) begin
                out_mean <= s3_mean;
                out_var  <= diff[DIFF_W-1] ? '0 : MSQ_W'(diff);
            end
        end
    end

endmodule

// File: rtl/frame_variance.sv
// Module: frame_variance (top)
// Single-pass variance and mean over consecutive frames of FRAME_LEN samples.
// Pipeline from the last accepted sample: snapshot, divide, square, subtract.
// out_valid pulses in the fourth cycle after the last sample.
// Assumes FRAME_LEN >= 2 and FRAC_W >= 1.
module frame_variance #(
    parameter int DATA_W    = 16,
    parameter int FRAME_LEN = 1000,
    parameter int FRAC_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic signed [DATA_W-1:0]        in_data,
    output logic                            out_valid,
    output logic signed [DATA_W+FRAC_W-1:0] out_mean,
    output logic [2*DATA_W+2*FRAC_W-1:0]    out_var
);

    localparam int LOG2N  = $clog2(FRAME_LEN);
    localparam int CNT_W  = LOG2N;
    localparam int SUM_W  = DATA_W + LOG2N;
    localparam int SQ_W   = 2 * DATA_W + LOG2N;
    localparam int MEAN_W = DATA_W + FRAC_W;
    localparam int MSQ_W  = 2 * DATA_W + 2 * FRAC_W;
    localparam logic [SUM_W-1:0] SUM_BIAS = SUM_W'(FRAME_LEN) << (DATA_W - 1);

    logic                    frame_done;
    logic [CNT_W-1:0]        cnt;
    logic signed [SUM_W-1:0] acc_sum;
    logic [SQ_W-1:0]         acc_sq;
    logic                    snap_valid;
    logic signed [SUM_W-1:0] snap_sum;
    logic [SQ_W-1:0]         snap_sq;
    logic [SUM_W-1:0]        sum_biased;
    logic                    s2_valid;
    logic [MEAN_W-1:0]       q_mean;
    logic [MSQ_W-1:0]        q_msq;

    fvar_accum #(
        .DATA_W   (DATA_W),
        .FRAME_LEN(FRAME_LEN),
        .CNT_W    (CNT_W),
        .SUM_W    (SUM_W),
        .SQ_W     (SQ_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .frame_done(frame_done),
        .cnt       (cnt),
        .acc_sum   (acc_sum),
        .acc_sq    (acc_sq),
        .snap_valid(snap_valid),
        .snap_sum  (snap_sum),
        .snap_sq   (snap_sq)
    );

    // Offset the signed sum so the divider only sees non-negative values.
    assign sum_biased = $unsigned(snap_sum) + SUM_BIAS;

    fvar_divn #(
        .FRAME_LEN(FRAME_LEN),
        .LOG2N    (LOG2N),
        .IN_W     (SUM_W),
        .SHIFT_UP (FRAC_W),
        .OUT_W    (MEAN_W)
    ) u_div_mean (
        .clk  (clk),
        .rst_n(rst_n),
        .v    (sum_biased),
        .q    (q_mean)
    );

    fvar_divn #(
        .FRAME_LEN(FRAME_LEN),
        .LOG2N    (LOG2N),
        .IN_W     (SQ_W),
        .SHIFT_UP (2 * FRAC_W),
        .OUT_W    (MSQ_W)
    ) u_div_msq (
        .clk  (clk),
        .rst_n(rst_n),
        .v    (snap_sq),
        .q    (q_msq)
    );

    // Valid bit that follows the divide stage.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_valid <= 1'b0;
        else        s2_valid <= snap_valid;
    end

    fvar_finish #(
        .MEAN_W(MEAN_W),
        .MSQ_W (MSQ_W)
    ) u_finish (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s2_valid),
        .q_mean   (q_mean),
        .q_msq    (q_msq),
        .out_valid(out_valid),
        .out_mean (out_mean),
        .out_var  (out_var)
    );

endmodule

// File: rtl/fvar_checker.sv
// Module: fvar_checker
// Temporal properties of frame_variance, attached to it with bind.
// Assumes it is connected to the top's frame-end strobe, count and accumulators.
module fvar_checker #(
    parameter int FRAME_LEN = 1000,
    parameter int CNT_W     = 10,
    parameter int SUM_W     = 26,
    parameter int SQ_W      = 42
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_done,
    input logic [CNT_W-1:0]        cnt,
    input logic signed [SUM_W-1:0] acc_sum,
    input logic [SQ_W-1:0]         acc_sq,
    input logic                    out_valid
);

    // R1: a reset cycle leaves the count at zero and out_valid low.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !out_valid));

    // R2: the sample count stays inside one frame.
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_LEN - 1));

    // R8: both totals restart right after a frame's last sample.
    a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (acc_sum == '0 && acc_sq == '0));

    // R7: every frame end yields out_valid four cycles later.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ##4 out_valid);

    // R7: out_valid only ever follows a frame end.
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(frame_done, 4));

    // R7: out_valid is a single-cycle pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

bind frame_variance fvar_checker #(
    .FRAME_LEN(FRAME_LEN),
    .CNT_W    (CNT_W),
    .SUM_W    (SUM_W),
    .SQ_W     (SQ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .cnt       (cnt),
    .acc_sum   (acc_sum),
    .acc_sq    (acc_sq),
    .out_valid (out_valid)
);

// File: tb/frame_variance_tb.sv
`timescale 1ns/1ps
// Bench: two engines (frame lengths 8 and 5, FRAC_W = 2) share one stream.
// The expected results come from exact integer arithmetic with floor division.
module frame_variance_tb;

    localparam int FW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic        v0, v1;
    logic signed [17:0] m0, m1;
    logic [35:0] r0, r1;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R4";

    typedef struct {
        int     cyc;
        longint mean;
        longint var_v;
        string  tag;
    } exp_t;
    exp_t q0[$];
    exp_t q1[$];
    longint ms[2];
    longint mq[2];
    int     mc[2];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frame_variance #(.DATA_W(16), .FRAME_LEN(8), .FRAC_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v0), .out_mean(m0), .out_var(r0));

    frame_variance #(.DATA_W(16), .FRAME_LEN(5), .FRAC_W(FW)) u_dut_np (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v1), .out_mean(m1), .out_var(r1));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic longint floor_div(input longint a, input longint b);
        longint q;
        q = a / b;
        if ((a % b != 0) && (a < 0)) q = q - 1;
        return q;
    endfunction

    // Reference model for one engine: accumulate, then emit the expected frame result.
    task automatic model(input int idx, input int d);
        longint n, mean, msq, vr;
        exp_t e;
        n = (idx == 0) ? 8 : 5;
        ms[idx] += d;
        mq[idx] += longint'(d) * longint'(d);
        mc[idx]++;
        if (mc[idx] == int'(n)) begin
            mean = floor_div(ms[idx] * (1 << FW), n);
            msq  = floor_div(mq[idx] * (1 << (2 * FW)), n);
            vr   = msq - mean * mean;
            if (vr < 0) vr = 0;                  // R5 clamp
            e.cyc = cyc + 4;                      // R7 latency
            e.mean = mean;
            e.var_v = vr;
            e.tag = cur_tag;
            if (idx == 0) q0.push_back(e); else q1.push_back(e);
            ms[idx] = 0; mq[idx] = 0; mc[idx] = 0;
        end
    endtask

    task automatic send(input bit v, input int d);
        in_valid = v;
        in_data = 16'(d);
        if (rst_n && v) begin
            model(0, d);
            model(1, d);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        send(1'b1, 777);                          // R1: ignored while in reset
        send(1'b1, -999);
        for (int i = 0; i < 2; i++) begin ms[i] = 0; mq[i] = 0; mc[i] = 0; end
        q0.delete();
        q1.delete();
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    task automatic watch(input int idx, input logic v, input longint m, input longint vr);
        exp_t e;
        bit have;
        have = (idx == 0) ? (q0.size() > 0) : (q1.size() > 0);
        if (have) e = (idx == 0) ? q0[0] : q1[0];
        if (have && e.cyc == cyc) begin
            if (idx == 0) void'(q0.pop_front()); else void'(q1.pop_front());
            chk(v === 1'b1, "R7 out_valid at fourth cycle", longint'(v), 1);
            chk(m == e.mean, {e.tag, " R3 mean"}, m, e.mean);
            chk(vr == e.var_v, {e.tag, " R4 variance"}, vr, e.var_v);
        end else if (v === 1'b1) begin
            chk(1'b0, "R7 unexpected out_valid", 1, 0);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            watch(0, v0, longint'(m0), longint'(r0));
            watch(1, v1, longint'(m1), longint'(r1));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lfsr;
        for (int i = 0; i < 2; i++) begin ms[i] = 0; mq[i] = 0; mc[i] = 0; end
        @(negedge clk);
        do_reset();
        // R1: state right after reset
        chk(v0 == 1'b0 && v1 == 1'b0, "R1 out_valid after reset", longint'(v0 | v1), 0);
        chk(m0 == 0 && m1 == 0, "R1 out_mean after reset", longint'(m0) + longint'(m1), 0);
        chk(r0 == 0 && r1 == 0, "R1 out_var after reset", longint'(r0) + longint'(r1), 0);

        // R2: ramp with idle cycles carrying garbage data
        cur_tag = "R2";
        for (int i = 0; i < 40; i++) begin
            send(1'b1, i * 37 - 500);
            send(1'b0, 12345);
        end

        // R6: full-scale frames, constant and alternating
        cur_tag = "R6";
        for (int i = 0; i < 40; i++) send(1'b1, -32768);
        for (int i = 0; i < 40; i++) send(1'b1, 32767);
        for (int i = 0; i < 40; i++) send(1'b1, (i % 2 == 0) ? -32768 : 32767);
        for (int i = 0; i < 40; i++) send(1'b1, (i % 3 == 0) ? 32767 : -32768);

        // R5: aligned frames of four -1 and one 0 drive the difference negative
        repeat (6) send(1'b0, 0);
        do_reset();
        cur_tag = "R5";
        for (int i = 0; i < 40; i++) send(1'b1, (i % 5 == 4) ? 0 : -1);

        // R8: continuous pseudo-random stream, no idle cycles
        cur_tag = "R8";
        lfsr = 32'h1ACE;
        for (int i = 0; i < 200; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            send(1'b1, (lfsr & 16'hFFFF) - 32768);
        end

        // R1: reset in the middle of a frame discards the partial frame
        send(1'b1, 30000);
        send(1'b1, -30000);
        send(1'b1, 1234);
        do_reset();
        cur_tag = "R1";
        for (int i = 0; i < 40; i++) send(1'b1, i * i - 100);

        // R9: sweep of all small value pairs through both divide forms
        cur_tag = "R9";
        for (int a = -12; a <= 12; a++) begin
            for (int b = -12; b <= 12; b++) begin
                send(1'b1, a);
                send(1'b1, b);
            end
        end

        repeat (12) send(1'b0, 0);
        chk(q0.size() == 0, "R7 all results delivered (N=8)", q0.size(), 0);
        chk(q1.size() == 0, "R7 all results delivered (N=5)", q1.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule